// File: doc/BRIEF.md
# Memory-Mapped Terminal Controller

A console peripheral that sits on a simple 32-bit processor bus and joins a keyboard-side byte stream and a display-side byte sink to software. Software sees four word registers inside one 16-byte window at `BASE_ADDR`. Each direction has a control word and a data word. The control word holds a read-only Ready flag in bit 0 and a writable Interrupt Enable in bit 1. Every bus access completes in the cycle it is presented: read data is valid in that cycle, and writes and read side effects take hold at the closing clock edge.

The receive side latches any byte offered with `kb_valid` and raises its Ready flag. A read of the receive data word returns that byte and drops Ready. The transmit side accepts a byte written to its data word while Ready is 1. It then presents the byte on a valid/ready handshake to the display sink and reports itself busy until the sink takes the byte. One level-sensitive interrupt line combines the two directions, so software can either poll the Ready flags or be interrupted by them.

Top module: `term_ctrl`

## Requirements
- R1: After reset, the receive control word reads 0, the transmit control word reads 1, `irq` is 0 and `disp_valid` is 0.
- R2: A byte offered with `kb_valid` sets receive Ready (bit 0 of the word at offset 0x0) from the next cycle. The word at offset 0x4 then returns that byte in bits 7:0, and all its higher bits are zero.
- R3: A bus read of offset 0x4 clears receive Ready from the next cycle. A read of either control word changes nothing.
- R4: A byte that arrives while receive Ready is 1 replaces the held byte, and Ready stays 1. This also applies when the byte arrives in the same cycle as a read of offset 0x4.
- R5: A write to offset 0xC while transmit Ready is 1 places bits 7:0 of the write data on `disp_byte`, with `disp_valid` high from the next cycle. Transmit Ready (bit 0 of the word at offset 0x8) then reads 0.
- R6: `disp_valid` and `disp_byte` hold steady until a cycle with `disp_ready` high. In the cycle after that handshake, `disp_valid` is 0 and transmit Ready reads 1 again.
- R7: A write to offset 0xC while transmit Ready is 0 is ignored, and the byte being presented does not change.
- R8: Bit 1 of each control word is a writable Interrupt Enable. Bit 0 cannot be changed by a bus write. All other control bits read as zero.
- R9: `irq` equals (receive IE AND receive Ready) OR (transmit IE AND transmit Ready), and it holds at that level until software changes the condition.
- R10: Reads of an address outside the window, and reads of offset 0xC, return zero. Writes outside the window and writes to offset 0x4 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the access; bits 1:0 are ignored |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| kb_valid | input | 1 | Keyboard byte present this cycle |
| kb_byte | input | 8 | Keyboard byte |
| disp_valid | output | 1 | A byte is offered to the display |
| disp_byte | output | 8 | Byte offered to the display |
| disp_ready | input | 1 | Display takes the offered byte |
| irq | output | 1 | Level interrupt request |

## Verification
Every one of the 256 byte values is sent through the receive side and then through the transmit side. For the transmit side, the handshake is withheld for a varying number of cycles, which separates correct zero-extension and hold behaviour from bit slips or early release. All sixteen combinations of the two enables and the two Ready flags are set up and compared against the `irq` formula, so an inverted or swapped term is caught. Targeted sequences exercise the collisions and the ignored accesses: a second byte arriving before a read, an arrival in the same cycle as a read, a write while busy, and accesses to unmapped offsets and to the rx data word.

// File: rtl/term_pkg.sv
package term_pkg;

    localparam int unsigned BUS_W   = 32;
    localparam int unsigned RDY_BIT = 0;
    localparam int unsigned IE_BIT  = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RX_CTRL,
        SEL_RX_DATA,
        SEL_TX_CTRL,
        SEL_TX_DATA
    } reg_sel_e;

    typedef enum logic {
        TX_IDLE,
        TX_SEND
    } tx_state_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        reg_sel_e         sel;
        logic [BUS_W-1:0] wdata;
    } bus_op_t;

    function automatic reg_sel_e decode_sel(input logic [BUS_W-1:0] addr,
                                            input logic [BUS_W-1:0] base);
        reg_sel_e s;
        if (addr[BUS_W-1:4] != base[BUS_W-1:4]) begin
            s = SEL_NONE;
        end else begin
            case (addr[3:2])
                2'd0:    s = SEL_RX_CTRL;
                2'd1:    s = SEL_RX_DATA;
                2'd2:    s = SEL_TX_CTRL;
                default: s = SEL_TX_DATA;
            endcase
        end
        return s;
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_word(input logic ie, input logic rdy);
        logic [BUS_W-1:0] w;
        w          = '0;
        w[RDY_BIT] = rdy;
        w[IE_BIT]  = ie;
        return w;
    endfunction

endpackage

// File: rtl/term_addr_dec.sv
module term_addr_dec
    import term_pkg::*;
#(
    parameter logic [BUS_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
    input  logic [BUS_W-1:0] addr,
    input  logic             rd,
    input  logic             wr,
    input  logic [BUS_W-1:0] wdata,
    output bus_op_t          op
);
    always_comb begin
        op.sel   = decode_sel(addr, BASE_ADDR);
        op.rd    = rd && (op.sel != SEL_NONE);
        op.wr    = wr && (op.sel != SEL_NONE);
        op.wdata = wdata;
    end
endmodule

// File: rtl/term_rx_chan.sv
module term_rx_chan
    import term_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic              kb_valid,
    input  logic [CHAR_W-1:0] kb_byte,
    output logic              rx_rdy,
    output logic              rx_ie,
    output logic [CHAR_W-1:0] rx_char
);
    logic ctrl_wr;
    logic data_rd;

    assign ctrl_wr = op.wr && (op.sel == SEL_RX_CTRL);
    assign data_rd = op.rd && (op.sel == SEL_RX_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_rdy  <= 1'b0;
            rx_ie   <= 1'b0;
            rx_char <= '0;
        end else begin
            if (ctrl_wr) begin
                rx_ie <= op.wdata[IE_BIT];
            end
            // new arrival wins over a same-cycle read
            if (kb_valid) begin
                rx_char <= kb_byte;
                rx_rdy  <= 1'b1;
            end else if (data_rd) begin
                rx_rdy  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/term_tx_chan.sv
module term_tx_chan
    import term_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic              disp_ready,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_byte,
    output logic              tx_rdy,
    output logic              tx_ie
);
    tx_state_e state;
    logic      ctrl_wr;
    logic      data_wr;

    assign ctrl_wr = op.wr && (op.sel == SEL_TX_CTRL);
    assign data_wr = op.wr && (op.sel == SEL_TX_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TX_IDLE;
            tx_ie     <= 1'b0;
            disp_byte <= '0;
        end else begin
            if (ctrl_wr) begin
                tx_ie <= op.wdata[IE_BIT];
            end
            case (state)
                TX_IDLE: begin
                    if (data_wr) begin
                        disp_byte <= op.wdata[CHAR_W-1:0];
                        state     <= TX_SEND;
                    end
                end
                default: begin
                    if (disp_ready) begin
                        state <= TX_IDLE;
                    end
                end
            endcase
        end
    end

    assign disp_valid = (state == TX_SEND);
    assign tx_rdy     = (state == TX_IDLE);
endmodule

// File: rtl/term_ctrl.sv
module term_ctrl
    import term_pkg::*;
#(
    parameter logic [BUS_W-1:0] BASE_ADDR = 32'hFFFF_0000,
    parameter int unsigned      CHAR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              kb_valid,
    input  logic [CHAR_W-1:0] kb_byte,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_byte,
    input  logic              disp_ready,
    output logic              irq
);
    localparam int unsigned PAD_W = BUS_W - CHAR_W;

    bus_op_t           op;
    logic              rx_rdy;
    logic              rx_ie;
    logic [CHAR_W-1:0] rx_char;
    logic              tx_rdy;
    logic              tx_ie;

    term_addr_dec #(.BASE_ADDR(BASE_ADDR)) u_dec (
        .addr  (bus_addr),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .op    (op)
    );

    term_rx_chan #(.CHAR_W(CHAR_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .kb_valid (kb_valid),
        .kb_byte  (kb_byte),
        .rx_rdy   (rx_rdy),
        .rx_ie    (rx_ie),
        .rx_char  (rx_char)
    );

    term_tx_chan #(.CHAR_W(CHAR_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .disp_ready (disp_ready),
        .disp_valid (disp_valid),
        .disp_byte  (disp_byte),
        .tx_rdy     (tx_rdy),
        .tx_ie      (tx_ie)
    );

    always_comb begin
        case (op.sel)
            SEL_RX_CTRL: bus_rdata = ctrl_word(rx_ie, rx_rdy);
            SEL_RX_DATA: bus_rdata = {{PAD_W{1'b0}}, rx_char};
            SEL_TX_CTRL: bus_rdata = ctrl_word(tx_ie, tx_rdy);
            default:     bus_rdata = '0;
        endcase
    end

    assign irq = (rx_ie && rx_rdy) || (tx_ie && tx_rdy);
endmodule

// File: rtl/term_ctrl_chk.sv
module term_ctrl_chk
    import term_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input bus_op_t           op,
    input logic              kb_valid,
    input logic [CHAR_W-1:0] kb_byte,
    input logic              rx_rdy,
    input logic              rx_ie,
    input logic [CHAR_W-1:0] rx_char,
    input logic              tx_rdy,
    input logic              tx_ie,
    input logic              disp_valid,
    input logic [CHAR_W-1:0] disp_byte,
    input logic              disp_ready,
    input logic              irq
);
    AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        kb_valid |=> rx_rdy && (rx_char == $past(kb_byte))); // R2

    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (op.rd && op.sel == SEL_RX_DATA && !kb_valid) |=> !rx_rdy); // R3

    AST_TX_START: assert property (@(posedge clk) disable iff (rst)
        (tx_rdy && op.wr && op.sel == SEL_TX_DATA)
        |=> disp_valid && !tx_rdy && (disp_byte == $past(op.wdata[CHAR_W-1:0]))); // R5

    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !disp_ready) |=> disp_valid && $stable(disp_byte)); // R6

    AST_DISP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_ready) |=> !disp_valid && tx_rdy); // R6

    AST_BUSY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!tx_rdy && !disp_ready && op.wr && op.sel == SEL_TX_DATA) |=> $stable(disp_byte)); // R7

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!rx_ie && !tx_ie) |-> !irq); // R9
endmodule

bind term_ctrl term_ctrl_chk #(.CHAR_W(CHAR_W)) u_chk (.*);

// File: tb/tb_term_ctrl.sv
module tb_term_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'hFFFF_0000;
    localparam logic [31:0] A_RXC = BASE + 32'h0;
    localparam logic [31:0] A_RXD = BASE + 32'h4;
    localparam logic [31:0] A_TXC = BASE + 32'h8;
    localparam logic [31:0] A_TXD = BASE + 32'hC;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        kb_valid;
    logic [7:0]  kb_byte;
    logic        disp_valid;
    logic [7:0]  disp_byte;
    logic        disp_ready;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    term_ctrl dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kb_valid(kb_valid), .kb_byte(kb_byte),
        .disp_valid(disp_valid), .disp_byte(disp_byte), .disp_ready(disp_ready), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 32'h0;
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 32'h0;
    endtask

    task automatic key(input logic [7:0] b);
        kb_byte = b; kb_valid = 1'b1;
        @(negedge clk);
        kb_valid = 1'b0;
    endtask

    task automatic drain();
        disp_ready = 1'b1;
        @(negedge clk);
        disp_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        kb_valid = 1'b0; kb_byte = '0; disp_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 disp_valid", {31'b0, disp_valid}, 32'h0);
        bus_read(A_RXC, d); chk("R1 rx ctrl", d, 32'h0);
        bus_read(A_TXC, d); chk("R1 tx ctrl", d, 32'h1);

        // R2/R3 receive sweep over all byte values
        for (int b = 0; b < 256; b++) begin
            key(8'(b));
            bus_read(A_RXC, d); chk("R2 rx ready set", d, 32'h1);
            bus_read(A_RXC, d); chk("R3 ctrl read no side effect", d, 32'h1);
            bus_read(A_RXD, d); chk("R2 rx data", d, 32'(b));
            bus_read(A_RXC, d); chk("R3 rx ready cleared", d, 32'h0);
        end

        // R4 overwrite while ready
        key(8'h31); key(8'h32);
        bus_read(A_RXC, d); chk("R4 ready stays", d, 32'h1);
        bus_read(A_RXD, d); chk("R4 newest byte", d, 32'h32);
        // R4 arrival in the same cycle as the data read
        key(8'h41);
        kb_byte = 8'h42; kb_valid = 1'b1;
        bus_read(A_RXD, d);
        kb_valid = 1'b0;
        chk("R4 read returns old byte", d, 32'h41);
        bus_read(A_RXC, d); chk("R4 ready kept on collision", d, 32'h1);
        bus_read(A_RXD, d); chk("R4 collision byte", d, 32'h42);

        // R5/R6 transmit sweep with varying sink stall
        for (int b = 0; b < 256; b++) begin
            bus_write(A_TXD, 32'hABCD_EF00 | 32'(b));
            chk("R5 disp_valid", {31'b0, disp_valid}, 32'h1);
            chk("R5 disp_byte", {24'b0, disp_byte}, 32'(b));
            bus_read(A_TXC, d); chk("R5 tx ready low", d, 32'h0);
            for (int k = 0; k < b % 3; k++) begin
                @(negedge clk);
                chk("R6 held valid", {31'b0, disp_valid}, 32'h1);
                chk("R6 held byte", {24'b0, disp_byte}, 32'(b));
            end
            drain();
            chk("R6 valid drops", {31'b0, disp_valid}, 32'h0);
            bus_read(A_TXC, d); chk("R6 tx ready back", d, 32'h1);
        end

        // R7 write while busy is ignored
        bus_write(A_TXD, 32'h5A);
        bus_write(A_TXD, 32'hA5);
        chk("R7 byte kept", {24'b0, disp_byte}, 32'h5A);
        drain();
        chk("R7 single transfer", {31'b0, disp_valid}, 32'h0);

        // R8 control bit layout
        bus_write(A_TXC, 32'hFFFF_FFFF);
        bus_read(A_TXC, d); chk("R8 tx ctrl ie set", d, 32'h3);
        bus_write(A_TXC, 32'hFFFF_FFFD);
        bus_read(A_TXC, d); chk("R8 tx ctrl ie clear", d, 32'h1);
        bus_write(A_RXC, 32'hFFFF_FFFF);
        bus_read(A_RXC, d); chk("R8 rx ready not writable", d, 32'h2);
        bus_write(A_RXC, 32'h0);

        // R9 all sixteen enable/ready combinations
        for (int c = 0; c < 16; c++) begin
            bus_write(A_RXC, {30'b0, c[0], 1'b0});
            bus_write(A_TXC, {30'b0, c[1], 1'b0});
            if (c[2]) key(8'(c)); else bus_read(A_RXD, d);
            if (!c[3]) bus_write(A_TXD, 32'(c));
            chk("R9 irq level", {31'b0, irq},
                {31'b0, (c[0] & c[2]) | (c[1] & c[3])});
            @(negedge clk);
            chk("R9 irq held", {31'b0, irq},
                {31'b0, (c[0] & c[2]) | (c[1] & c[3])});
            if (!c[3]) drain();
        end
        bus_write(A_RXC, 32'h0);
        bus_write(A_TXC, 32'h0);
        bus_read(A_RXD, d);

        // R10 unmapped and ignored accesses
        bus_read(BASE + 32'h10, d); chk("R10 unmapped above", d, 32'h0);
        bus_read(BASE - 32'h4, d); chk("R10 unmapped below", d, 32'h0);
        bus_read(32'h0000_0008, d); chk("R10 low address", d, 32'h0);
        bus_read(A_TXD, d); chk("R10 tx data reads zero", d, 32'h0);
        bus_write(BASE + 32'h18, 32'hFFFF_FFFF);
        bus_write(32'h0000_000C, 32'hFF);
        chk("R10 no send from unmapped", {31'b0, disp_valid}, 32'h0);
        bus_read(A_TXC, d); chk("R10 tx ctrl untouched", d, 32'h1);
        bus_read(A_RXC, d); chk("R10 rx ctrl untouched", d, 32'h0);
        key(8'h77);
        bus_write(A_RXD, 32'h99);
        bus_read(A_RXC, d); chk("R10 rx data write keeps ready", d, 32'h1);
        bus_read(A_RXD, d); chk("R10 rx data write ignored", d, 32'h77);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule